// File: doc/BRIEF.md
# Strap-Loaded Hub Configuration Register

This block holds one 8-bit configuration byte for a hub controller. While synchronous reset is held the byte is cleared. On the first clock edge after reset is released, five strap pins are copied into bits 5 down to 1 and the two upper bits stay cleared. After that the straps have no further effect.

Once the straps are captured, the byte can be replaced from one of two writers, and a mode input chooses which one. With the mode input low (I2C mode) only the serial-EEPROM loader strobe is honoured. With the mode input high (SMBus mode) only the host write strobe is honoured. Bit 0 is reserved and is always 0. The stored bits drive seven control outputs. Two power-policy outputs are decoded combinationally from the full-power-management bit and a self-powered input.

Top module: `hub_cfg_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rd_data` reads 8'h00 after that edge.
- R2: At the first rising edge with `rst` low after reset, bits [5:1] of `rd_data` take the strap levels: bit 5 `strap_lpm_dis`, bit 4 `strap_port_ind`, bit 3 `strap_ganged`, bit 2 `strap_fpm`, bit 1 `strap_tmr_ovr`. Bits 7, 6 and 0 read 0.
- R3: After the capture edge, changes on the strap pins leave `rd_data` unchanged.
- R4: `rd_data[0]` reads 0 at all times, including after a write of a byte whose bit 0 is 1.
- R5: With `mode_smbus` low, a high `ee_load` at a rising edge stores `ee_data[7:1]` into bits [7:1], visible after that edge. `host_wr` has no effect.
- R6: With `mode_smbus` high, a high `host_wr` at a rising edge stores `host_data[7:1]` into bits [7:1], visible after that edge. `ee_load` has no effect.
- R7: When `ee_load` and `host_wr` are both high at the same edge, only the writer selected by `mode_smbus` changes the byte.
- R8: A write strobe at the strap-capture edge is ignored, and the strap value is stored.
- R9: The outputs `cfg_str_en`, `cfg_ser_en`, `cfg_lpm_dis`, `cfg_port_ind`, `cfg_ganged`, `cfg_fpm` and `cfg_tmr_ovr` equal `rd_data` bits 7, 6, 5, 4, 3, 2 and 1 respectively.
- R10: When `cfg_fpm` is 0, `pwr_sw_en` and `ocd_en` are both 1. When it is 1 and `self_powered` is 0, only `pwr_sw_en` is 1. When it is 1 and `self_powered` is 1, only `ocd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_smbus | input | 1 | 1 selects the host writer, 0 selects the EEPROM loader |
| strap_lpm_dis | input | 1 | Strap level for the link-power-management disable bit |
| strap_port_ind | input | 1 | Strap level for the port-indicator bit |
| strap_ganged | input | 1 | Strap level for the ganged-power bit |
| strap_fpm | input | 1 | Strap level for the full-power-management bit |
| strap_tmr_ovr | input | 1 | Strap level for the timer-override bit |
| ee_load | input | 1 | EEPROM loader write strobe |
| ee_data | input | 8 | EEPROM loader data byte |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 8 | Host write data byte |
| self_powered | input | 1 | 1 when the hub is self-powered |
| rd_data | output | 8 | Current register value |
| cfg_str_en | output | 1 | Custom-string enable |
| cfg_ser_en | output | 1 | Custom serial-number enable |
| cfg_lpm_dis | output | 1 | Link low-power state disable |
| cfg_port_ind | output | 1 | Port-indicator enable |
| cfg_ganged | output | 1 | Ganged power control |
| cfg_fpm | output | 1 | Full-power-management bit |
| cfg_tmr_ovr | output | 1 | Timer override |
| pwr_sw_en | output | 1 | Power switching enabled |
| ocd_en | output | 1 | Over-current detection enabled |

## Verification
The hardest case to reach is the single capture edge: a write strobe has to land on exactly the first cycle after reset release. Two sources must also collide at that edge, and later strap changes must be shown to have no effect. The stimulus releases reset several times with different strap patterns. In one release both strobes are held high across the release edge. After each capture the straps are toggled while no writer is active. A long mixed phase with random mode, strobes, data and self-powered level then hits the colliding-strobe case in both modes, and it is compared every cycle against a behavioural model.

// File: rtl/hub_cfg_pkg.sv
package hub_cfg_pkg;
   localparam int unsigned CFG_W = 8;

   localparam int unsigned B_STR  = 7;
   localparam int unsigned B_SER  = 6;
   localparam int unsigned B_LPM  = 5;
   localparam int unsigned B_PIND = 4;
   localparam int unsigned B_GANG = 3;
   localparam int unsigned B_FPM  = 2;
   localparam int unsigned B_TMR  = 1;
   localparam int unsigned B_RSVD = 0;

   typedef struct packed {
      logic lpm_dis;
      logic port_ind;
      logic ganged;
      logic fpm;
      logic tmr_ovr;
   } strap_t;

   function automatic logic [CFG_W-1:0] strap_word(input strap_t s);
      logic [CFG_W-1:0] w;
      w         = '0;
      w[B_LPM]  = s.lpm_dis;
      w[B_PIND] = s.port_ind;
      w[B_GANG] = s.ganged;
      w[B_FPM]  = s.fpm;
      w[B_TMR]  = s.tmr_ovr;
      return w;
   endfunction
endpackage

// File: rtl/hub_cfg_strap_capture.sv
module hub_cfg_strap_capture (
   input  logic clk,
   input  logic rst,
   output logic cap
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b1;
      else     pend_q <= 1'b0;
   end

   // High during the one cycle that follows reset release.
   assign cap = pend_q & ~rst;
endmodule

// File: rtl/hub_cfg_src_sel.sv
module hub_cfg_src_sel #(
   parameter int unsigned W = 8
) (
   input  logic         mode_smbus,
   input  logic         cap,
   input  logic         ee_load,
   input  logic [W-1:0] ee_data,
   input  logic         host_wr,
   input  logic [W-1:0] host_data,
   output logic         we,
   output logic [W-1:0] wdata
);
   always_comb begin
      if (mode_smbus) begin
         we    = host_wr;
         wdata = host_data;
      end else begin
         we    = ee_load;
         wdata = ee_data;
      end
      // Strap capture owns the first cycle after reset.
      if (cap) we = 1'b0;
   end
endmodule

// File: rtl/hub_cfg_store.sv
module hub_cfg_store #(
   parameter int unsigned    W         = 8,
   parameter logic [W-1:0]   RSVD_MASK = 8'h01
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap,
   input  logic [W-1:0] cap_word,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (RSVD_MASK[i]) begin : g_rsvd
         assign q[i] = 1'b0;
      end else begin : g_rw
         logic b_q;
         always_ff @(posedge clk) begin
            if (rst)      b_q <= 1'b0;
            else if (cap) b_q <= cap_word[i];
            else if (we)  b_q <= wdata[i];
         end
         assign q[i] = b_q;
      end
   end
endmodule

// File: rtl/hub_cfg_pwr_decode.sv
module hub_cfg_pwr_decode (
   input  logic fpm,
   input  logic self_powered,
   output logic pwr_sw_en,
   output logic ocd_en
);
   always_comb begin
      pwr_sw_en = 1'b1;
      ocd_en    = 1'b1;
      if (fpm) begin
         pwr_sw_en = ~self_powered;
         ocd_en    = self_powered;
      end
   end
endmodule

// File: rtl/hub_cfg_reg.sv
module hub_cfg_reg
   import hub_cfg_pkg::*;
#(
   parameter int unsigned        REG_W      = 8,
   parameter logic [REG_W-1:0]   RSVD_MASK  = 8'h01,
   parameter logic [REG_W-1:0]   STRAP_MASK = 8'h3E
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_smbus,
   input  logic             strap_lpm_dis,
   input  logic             strap_port_ind,
   input  logic             strap_ganged,
   input  logic             strap_fpm,
   input  logic             strap_tmr_ovr,
   input  logic             ee_load,
   input  logic [REG_W-1:0] ee_data,
   input  logic             host_wr,
   input  logic [REG_W-1:0] host_data,
   input  logic             self_powered,
   output logic [REG_W-1:0] rd_data,
   output logic             cfg_str_en,
   output logic             cfg_ser_en,
   output logic             cfg_lpm_dis,
   output logic             cfg_port_ind,
   output logic             cfg_ganged,
   output logic             cfg_fpm,
   output logic             cfg_tmr_ovr,
   output logic             pwr_sw_en,
   output logic             ocd_en
);
   localparam logic [REG_W-1:0] OVERLAP = RSVD_MASK & STRAP_MASK;

   if (REG_W != CFG_W) begin : g_bad_width
      $error("hub_cfg_reg: REG_W must equal the package field layout width");
   end
   if (OVERLAP != '0) begin : g_bad_mask
      $error("hub_cfg_reg: a reserved bit cannot also be strap-loaded");
   end

   strap_t           straps;
   logic             cap;
   logic             we;
   logic [REG_W-1:0] wdata;
   logic [REG_W-1:0] cap_word;
   logic [REG_W-1:0] q;

   assign straps   = '{lpm_dis:  strap_lpm_dis,  port_ind: strap_port_ind,
                       ganged:   strap_ganged,   fpm:      strap_fpm,
                       tmr_ovr:  strap_tmr_ovr};
   assign cap_word = strap_word(straps) & STRAP_MASK;

   hub_cfg_strap_capture u_cap (
      .clk (clk),
      .rst (rst),
      .cap (cap)
   );

   hub_cfg_src_sel #(.W(REG_W)) u_sel (
      .mode_smbus (mode_smbus),
      .cap        (cap),
      .ee_load    (ee_load),
      .ee_data    (ee_data),
      .host_wr    (host_wr),
      .host_data  (host_data),
      .we         (we),
      .wdata      (wdata)
   );

   hub_cfg_store #(.W(REG_W), .RSVD_MASK(RSVD_MASK)) u_store (
      .clk      (clk),
      .rst      (rst),
      .cap      (cap),
      .cap_word (cap_word),
      .we       (we),
      .wdata    (wdata),
      .q        (q)
   );

   hub_cfg_pwr_decode u_pwr (
      .fpm          (q[B_FPM]),
      .self_powered (self_powered),
      .pwr_sw_en    (pwr_sw_en),
      .ocd_en       (ocd_en)
   );

   assign rd_data      = q;
   assign cfg_str_en   = q[B_STR];
   assign cfg_ser_en   = q[B_SER];
   assign cfg_lpm_dis  = q[B_LPM];
   assign cfg_port_ind = q[B_PIND];
   assign cfg_ganged   = q[B_GANG];
   assign cfg_fpm      = q[B_FPM];
   assign cfg_tmr_ovr  = q[B_TMR];
endmodule

// File: rtl/hub_cfg_reg_chk.sv
module hub_cfg_reg_chk (
   input logic       clk,
   input logic       rst,
   input logic       mode_smbus,
   input logic       strap_lpm_dis,
   input logic       strap_port_ind,
   input logic       strap_ganged,
   input logic       strap_fpm,
   input logic       strap_tmr_ovr,
   input logic       ee_load,
   input logic [7:0] ee_data,
   input logic       host_wr,
   input logic [7:0] host_data,
   input logic       self_powered,
   input logic [7:0] rd_data,
   input logic       cfg_str_en,
   input logic       cfg_ser_en,
   input logic       cfg_lpm_dis,
   input logic       cfg_port_ind,
   input logic       cfg_ganged,
   input logic       cfg_fpm,
   input logic       cfg_tmr_ovr,
   input logic       pwr_sw_en,
   input logic       ocd_en
);
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> rd_data == 8'h00);

   p_strap_capture_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |=> rd_data == $past({2'b00, strap_lpm_dis, strap_port_ind,
                                       strap_ganged, strap_fpm, strap_tmr_ovr, 1'b0}));

   p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst) rd_data[0] == 1'b0);

   p_ee_write_r5: assert property (@(posedge clk) disable iff (rst)
      (!$fell(rst) && !mode_smbus && ee_load) |=> rd_data[7:1] == $past(ee_data[7:1]));

   p_i2c_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!$fell(rst) && !mode_smbus && !ee_load) |=> $stable(rd_data));

   p_host_write_r6: assert property (@(posedge clk) disable iff (rst)
      (!$fell(rst) && mode_smbus && host_wr) |=> rd_data[7:1] == $past(host_data[7:1]));

   p_smb_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!$fell(rst) && mode_smbus && !host_wr) |=> $stable(rd_data));

   p_capture_wins_r8: assert property (@(posedge clk) disable iff (rst)
      ($fell(rst) && (ee_load || host_wr)) |=> rd_data[7:6] == 2'b00);

   p_mirror_r9: assert property (@(posedge clk) disable iff (rst)
      {cfg_str_en, cfg_ser_en, cfg_lpm_dis, cfg_port_ind, cfg_ganged,
       cfg_fpm, cfg_tmr_ovr} == rd_data[7:1]);

   p_pwr_full_r10: assert property (@(posedge clk) disable iff (rst)
      !cfg_fpm |-> (pwr_sw_en && ocd_en));

   p_pwr_split_r10: assert property (@(posedge clk) disable iff (rst)
      cfg_fpm |-> (pwr_sw_en == !self_powered) && (ocd_en == self_powered));
endmodule

bind hub_cfg_reg hub_cfg_reg_chk chk_i (.*);

// File: tb/hub_cfg_reg_tb_top.sv
`timescale 1ns/1ps
module hub_cfg_reg_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mode_smbus = 1'b0;
   logic [4:0] st = 5'b0;
   logic       ee_load = 1'b0;
   logic [7:0] ee_data = 8'h00;
   logic       host_wr = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic       self_powered = 1'b0;
   logic [7:0] rd_data;
   logic       cfg_str_en, cfg_ser_en, cfg_lpm_dis, cfg_port_ind;
   logic       cfg_ganged, cfg_fpm, cfg_tmr_ovr, pwr_sw_en, ocd_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   hub_cfg_reg dut_i (
      .clk(clk), .rst(rst), .mode_smbus(mode_smbus),
      .strap_lpm_dis(st[4]), .strap_port_ind(st[3]), .strap_ganged(st[2]),
      .strap_fpm(st[1]), .strap_tmr_ovr(st[0]),
      .ee_load(ee_load), .ee_data(ee_data), .host_wr(host_wr), .host_data(host_data),
      .self_powered(self_powered), .rd_data(rd_data),
      .cfg_str_en(cfg_str_en), .cfg_ser_en(cfg_ser_en), .cfg_lpm_dis(cfg_lpm_dis),
      .cfg_port_ind(cfg_port_ind), .cfg_ganged(cfg_ganged), .cfg_fpm(cfg_fpm),
      .cfg_tmr_ovr(cfg_tmr_ovr), .pwr_sw_en(pwr_sw_en), .ocd_en(ocd_en)
   );

   // Behavioural reference model
   logic [7:0] m_val = 8'h00;
   bit         m_fresh = 1'b1;
   string      m_tag = "R1";

   always @(posedge clk) begin
      bit allowed, other;
      logic [7:0] d;
      allowed = mode_smbus ? host_wr : ee_load;
      other   = mode_smbus ? ee_load : host_wr;
      d       = mode_smbus ? host_data : ee_data;
      if (rst) begin
         m_val = 8'h00; m_fresh = 1'b1; m_tag = "R1";
      end else if (m_fresh) begin
         m_val = {2'b00, st, 1'b0}; m_fresh = 1'b0;
         m_tag = (ee_load || host_wr) ? "R8" : "R2";
      end else if (allowed) begin
         m_val = {d[7:1], 1'b0};
         if (other)      m_tag = "R7";
         else if (d[0])  m_tag = "R4";
         else            m_tag = mode_smbus ? "R6" : "R5";
      end else if (other) begin
         m_tag = mode_smbus ? "R6" : "R5";
      end else begin
         m_tag = "R3";
      end
      #1 compare();
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   task automatic compare();
      logic e_sw, e_ocd;
      chk(m_tag, rd_data, m_val);
      // R9: control outputs mirror bits 7..1
      chk("R9", {1'b0, cfg_str_en, cfg_ser_en, cfg_lpm_dis, cfg_port_ind,
                 cfg_ganged, cfg_fpm, cfg_tmr_ovr}, {1'b0, m_val[7:1]});
      // R10: power policy decode
      e_sw  = !m_val[2] || !self_powered;
      e_ocd = !m_val[2] || self_powered;
      chk("R10", {6'b0, pwr_sw_en, ocd_en}, {6'b0, e_sw, e_ocd});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ee_load = 1'b0; host_wr = 1'b0;
      end
   endtask

   task automatic wr(input bit smb, input bit e, input logic [7:0] ed,
                     input bit h, input logic [7:0] hd);
      @(negedge clk);
      mode_smbus = smb; ee_load = e; ee_data = ed; host_wr = h; host_data = hd;
   endtask

   initial begin
      // R1: reset state
      st = 5'b10110;
      idle(3);
      // R2: capture with idle strobes
      @(negedge clk); rst = 1'b0;
      idle(2);
      // R3: straps ignored afterwards
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); st = st ^ 5'b11111; self_powered = i[0];
      end
      // R4 / R5: I2C loader writes, bit 0 forced low
      wr(1'b0, 1'b1, 8'hFF, 1'b0, 8'h00);
      wr(1'b0, 1'b1, 8'h54, 1'b0, 8'h00);
      // R5: host ignored in I2C mode
      wr(1'b0, 1'b0, 8'h00, 1'b1, 8'hAB);
      // R6: host writes in SMBus mode, loader ignored
      wr(1'b1, 1'b0, 8'h00, 1'b1, 8'hC3);
      wr(1'b1, 1'b1, 8'h3C, 1'b0, 8'h00);
      // R7: colliding strobes in both modes
      wr(1'b1, 1'b1, 8'h11, 1'b1, 8'hEE);
      wr(1'b0, 1'b1, 8'h66, 1'b1, 8'h99);
      idle(2);
      // R8: strobes held across the capture edge
      @(negedge clk); rst = 1'b1;
      idle(2);
      @(negedge clk);
      st = 5'b01001; mode_smbus = 1'b1; host_wr = 1'b1; host_data = 8'hF0;
      ee_load = 1'b1; ee_data = 8'h0F; rst = 1'b0;
      idle(2);
      @(negedge clk); rst = 1'b1;
      idle(1);
      @(negedge clk);
      st = 5'b11111; mode_smbus = 1'b0; ee_load = 1'b1; ee_data = 8'hAA; rst = 1'b0;
      idle(2);
      // Mixed random phase
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         mode_smbus   = $urandom_range(1, 0);
         ee_load      = $urandom_range(1, 0);
         host_wr      = $urandom_range(1, 0);
         ee_data      = 8'($urandom);
         host_data    = 8'($urandom);
         self_powered = $urandom_range(1, 0);
         st           = 5'($urandom);
         rst          = ($urandom_range(39, 0) == 0);
      end
      idle(3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule